// File: doc/BRIEF.md
# MSI Directory Parent Controller

This block is the upper level of a two-level coherent memory system. It owns every one-word line and keeps, for each line, the data word, a directory entry per child cache (I, S or M) and a per-child flag that says a downgrade has been sent to that child and its answer is still awaited. Child caches ask for a line in S or M on a request channel and hand back data or a lowered state on a separate response channel. The controller grants a request only once no other child holds the line in a state that clashes with the one asked for. Until then it sends downgrades to the clashing children, one per cycle.

Responses from children are always taken ahead of requests. This covers answers to downgrades and also unprompted write-backs from evictions. A response can therefore never wait behind a request, and a request can never slip past a response that is already on offer. Requests from different children are merged by a round-robin arbiter. A grant or a downgrade appears on registered broadcast outputs tagged with the child index. Children are expected to take these outputs in the cycle they are shown.

Top module: `msi_dir_parent`

## Requirements
- R1: After reset every directory entry is I, every waiting flag is clear, every data word is zero, and no ready, grant or downgrade output is active.
- R2: A request from child c for state y (codes I=0, S=1, M=2) is granted only if every other child's directory entry is compatible with y. The pairs (M,M), (M,S) and (S,M) are incompatible; all other pairs are compatible, so several children may share S.
- R3: A grant raises `grantHasData` and carries the line's data word only when the requester's directory entry was I. Otherwise `grantHasData` is 0 and `grantData` is zero.
- R4: A granted request is acknowledged by `childReqReady` in the deciding cycle, and the grant appears on the grant outputs one cycle later. From then on, the requester's directory entry equals the granted state.
- R5: While the selected request has clashing children whose flag is clear, the lowest-index such child is sent one downgrade per cycle, and that child's flag is set. The target state is I when y is M and S when y is S.
- R6: A child whose waiting flag is set gets no further downgrade for that line, and a request from that child for that line is not granted until it has responded.
- R7: On a response from child c, the data word is written only if c's directory entry was M. The entry then takes the responded state and c's waiting flag clears. An unprompted write-back is handled the same way.
- R8: When any response is offered, exactly one response is accepted (the lowest-index child) and no request is granted or downgraded in that cycle.
- R9: Competing requests are served round-robin. After a grant to child k, the search for the next request starts at child k+1, wrapping to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| childReqValid | input | N | Request offered, one bit per child |
| childReqReady | output | N | Request accepted (granted) this cycle |
| childReqAddr | input | N*AW | Request line address, child i at bits [i*AW +: AW] |
| childReqState | input | N*2 | Requested state (1=S, 2=M), child i at bits [i*2 +: 2] |
| childRspValid | input | N | Response offered, one bit per child |
| childRspReady | output | N | Response accepted this cycle |
| childRspAddr | input | N*AW | Response line address |
| childRspState | input | N*2 | State the child now holds (0=I, 1=S) |
| childRspData | input | N*DW | Write-back data word |
| grantValid | output | 1 | Grant message valid |
| grantChild | output | CW | Index of the granted child |
| grantAddr | output | AW | Granted line address |
| grantState | output | 2 | Granted state |
| grantHasData | output | 1 | Grant carries data |
| grantData | output | DW | Line data (zero when no data) |
| downValid | output | 1 | Downgrade message valid |
| downChild | output | CW | Index of the child to downgrade |
| downAddr | output | AW | Line address to downgrade |
| downState | output | 2 | Highest state the child may keep (0=I, 1=S) |

## Verification
The checks assume that children send only the legal state codes: requests ask for S or M, and responses report I or S. They also assume that a child takes the grant and downgrade outputs in the cycle they are shown. The stimulus drives one request or response at a time from a table, and every request uses only the codes 1 or 2. Every response reports a state at or below the one the directory records, as a real child would after a downgrade or an eviction. The directed tests offer several channels at once only to exercise arbitration and priority. In those tests every offered state is legal.

// File: rtl/msi_dir_pkg.sv
package msi_dir_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } msi_t;

  // index width able to name up to 16 children
  localparam int KID_W = 4;
  typedef logic [KID_W-1:0] kid_t;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic takeRsp;
    kid_t rspKid;
    logic grant;
    logic down;
    kid_t downKid;
    msi_t downTo;
  } dir_strobe_t;

  // two holders may coexist unless one of them is M and the other is not I
  function automatic logic compatible(msi_t a, msi_t b);
    return !((a == ST_M && b != ST_I) || (b == ST_M && a != ST_I));
  endfunction

endpackage

// File: rtl/msi_dir_ctrl.sv
module msi_dir_ctrl
  import msi_dir_pkg::*;
#(
  parameter int N = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [N-1:0] reqValid,
  input  msi_t        reqState [N],
  input  logic [N-1:0] rspValid,
  input  msi_t        lineDir  [N],
  input  logic [N-1:0] lineWait,
  output kid_t        selKid,
  output dir_strobe_t strb,
  output logic [N-1:0] reqReady,
  output logic [N-1:0] rspReady
);

  kid_t         ptr;
  kid_t         rspKid;
  kid_t         downKid;
  logic         reqAny, rspAny, ownWait, downAny;
  msi_t         want;
  logic [N-1:0] conflict;

  // selection: lowest-index response, round-robin request
  always_comb begin : pick
    rspAny = 1'b0;
    rspKid = '0;
    for (int i = 0; i < N; i++) begin
      if (rspValid[i] && !rspAny) begin
        rspAny = 1'b1;
        rspKid = kid_t'(i);
      end
    end
    reqAny = 1'b0;
    selKid = '0;
    want   = ST_I;
    for (int k = 0; k < N; k++) begin
      for (int j = 0; j < N; j++) begin
        if (!reqAny && reqValid[j] && j == (int'(ptr) + k) % N) begin
          reqAny = 1'b1;
          selKid = kid_t'(j);
          want   = reqState[j];
        end
      end
    end
  end

  // decision on the selected request against its line's directory
  always_comb begin : decide
    ownWait  = 1'b0;
    conflict = '0;
    for (int i = 0; i < N; i++) begin
      if (kid_t'(i) == selKid) ownWait = lineWait[i];
      else conflict[i] = !compatible(lineDir[i], want);
    end
    downAny = 1'b0;
    downKid = '0;
    for (int i = 0; i < N; i++) begin
      if (conflict[i] && !lineWait[i] && !downAny) begin
        downAny = 1'b1;
        downKid = kid_t'(i);
      end
    end
    strb.takeRsp = rspAny;
    strb.rspKid  = rspKid;
    strb.grant   = !rspAny && reqAny && (conflict == '0) && !ownWait;
    strb.down    = !rspAny && reqAny && downAny;
    strb.downKid = downKid;
    strb.downTo  = (want == ST_M) ? ST_I : ST_S;
    for (int i = 0; i < N; i++) begin
      reqReady[i] = strb.grant && (selKid == kid_t'(i));
      rspReady[i] = rspAny && (rspKid == kid_t'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (strb.grant) ptr <= (selKid == kid_t'(N - 1)) ? '0 : selKid + kid_t'(1);
  end

endmodule

// File: rtl/msi_dir_dpath.sv
module msi_dir_dpath
  import msi_dir_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 2,
  parameter int DW = 8,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  dir_strobe_t   strb,
  input  kid_t          selKid,
  input  logic [AW-1:0] reqAddr  [N],
  input  msi_t          reqState [N],
  input  logic [AW-1:0] rspAddr  [N],
  input  msi_t          rspState [N],
  input  logic [DW-1:0] rspData  [N],
  output msi_t          lineDir  [N],
  output logic [N-1:0]  lineWait,
  output logic          grantValid,
  output logic [CW-1:0] grantChild,
  output logic [AW-1:0] grantAddr,
  output logic [1:0]    grantState,
  output logic          grantHasData,
  output logic [DW-1:0] grantData,
  output logic          downValid,
  output logic [CW-1:0] downChild,
  output logic [AW-1:0] downAddr,
  output logic [1:0]    downState
);

  localparam int LINES = 1 << AW;

  logic [DW-1:0] lineData [LINES];
  msi_t          dirMem   [LINES][N];
  logic          waitMem  [LINES][N];

  logic [AW-1:0] ra, pa;
  msi_t          ry, ps;
  logic [DW-1:0] pd;
  logic          reqWasI, rspWasM;

  always_comb begin : reqSide
    ra = '0;
    ry = ST_I;
    for (int i = 0; i < N; i++) begin
      if (kid_t'(i) == selKid) begin
        ra = reqAddr[i];
        ry = reqState[i];
      end
    end
    reqWasI = 1'b0;
    for (int i = 0; i < N; i++) begin
      lineDir[i]  = dirMem[ra][i];
      lineWait[i] = waitMem[ra][i];
      if (kid_t'(i) == selKid) reqWasI = (dirMem[ra][i] == ST_I);
    end
  end

  always_comb begin : rspSide
    pa = '0;
    ps = ST_I;
    pd = '0;
    for (int i = 0; i < N; i++) begin
      if (kid_t'(i) == strb.rspKid) begin
        pa = rspAddr[i];
        ps = rspState[i];
        pd = rspData[i];
      end
    end
    rspWasM = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (kid_t'(i) == strb.rspKid) rspWasM = (dirMem[pa][i] == ST_M);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < LINES; a++) begin
        lineData[a] <= '0;
        for (int i = 0; i < N; i++) begin
          dirMem[a][i]  <= ST_I;
          waitMem[a][i] <= 1'b0;
        end
      end
      grantValid   <= 1'b0;
      grantChild   <= '0;
      grantAddr    <= '0;
      grantState   <= '0;
      grantHasData <= 1'b0;
      grantData    <= '0;
      downValid    <= 1'b0;
      downChild    <= '0;
      downAddr     <= '0;
      downState    <= '0;
    end else begin
      grantValid <= strb.grant;
      downValid  <= strb.down;
      if (strb.grant) begin
        grantChild   <= CW'(selKid);
        grantAddr    <= ra;
        grantState   <= ry;
        grantHasData <= reqWasI;
        grantData    <= reqWasI ? lineData[ra] : '0;
        for (int i = 0; i < N; i++)
          if (kid_t'(i) == selKid) dirMem[ra][i] <= ry;
      end
      if (strb.down) begin
        downChild <= CW'(strb.downKid);
        downAddr  <= ra;
        downState <= strb.downTo;
        for (int i = 0; i < N; i++)
          if (kid_t'(i) == strb.downKid) waitMem[ra][i] <= 1'b1;
      end
      if (strb.takeRsp) begin
        if (rspWasM) lineData[pa] <= pd;
        for (int i = 0; i < N; i++) begin
          if (kid_t'(i) == strb.rspKid) begin
            dirMem[pa][i]  <= ps;
            waitMem[pa][i] <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/msi_dir_parent.sv
module msi_dir_parent
  import msi_dir_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 2,
  parameter int DW = 8,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N-1:0]    childReqValid,
  output logic [N-1:0]    childReqReady,
  input  logic [N*AW-1:0] childReqAddr,
  input  logic [N*2-1:0]  childReqState,
  input  logic [N-1:0]    childRspValid,
  output logic [N-1:0]    childRspReady,
  input  logic [N*AW-1:0] childRspAddr,
  input  logic [N*2-1:0]  childRspState,
  input  logic [N*DW-1:0] childRspData,
  output logic            grantValid,
  output logic [CW-1:0]   grantChild,
  output logic [AW-1:0]   grantAddr,
  output logic [1:0]      grantState,
  output logic            grantHasData,
  output logic [DW-1:0]   grantData,
  output logic            downValid,
  output logic [CW-1:0]   downChild,
  output logic [AW-1:0]   downAddr,
  output logic [1:0]      downState
);

  logic [AW-1:0] reqAddrA [N];
  msi_t          reqStateA[N];
  logic [AW-1:0] rspAddrA [N];
  msi_t          rspStateA[N];
  logic [DW-1:0] rspDataA [N];
  msi_t          lineDir  [N];
  logic [N-1:0]  lineWait;
  kid_t          selKid;
  dir_strobe_t   strb;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign reqAddrA[g]  = childReqAddr[g*AW +: AW];
    assign reqStateA[g] = msi_t'(childReqState[g*2 +: 2]);
    assign rspAddrA[g]  = childRspAddr[g*AW +: AW];
    assign rspStateA[g] = msi_t'(childRspState[g*2 +: 2]);
    assign rspDataA[g]  = childRspData[g*DW +: DW];
  end

  msi_dir_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (childReqValid),
    .reqState (reqStateA),
    .rspValid (childRspValid),
    .lineDir  (lineDir),
    .lineWait (lineWait),
    .selKid   (selKid),
    .strb     (strb),
    .reqReady (childReqReady),
    .rspReady (childRspReady)
  );

  msi_dir_dpath #(.N(N), .AW(AW), .DW(DW), .CW(CW)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .selKid       (selKid),
    .reqAddr      (reqAddrA),
    .reqState     (reqStateA),
    .rspAddr      (rspAddrA),
    .rspState     (rspStateA),
    .rspData      (rspDataA),
    .lineDir      (lineDir),
    .lineWait     (lineWait),
    .grantValid   (grantValid),
    .grantChild   (grantChild),
    .grantAddr    (grantAddr),
    .grantState   (grantState),
    .grantHasData (grantHasData),
    .grantData    (grantData),
    .downValid    (downValid),
    .downChild    (downChild),
    .downAddr     (downAddr),
    .downState    (downState)
  );

endmodule

// File: rtl/msi_dir_parent_chk.sv
module msi_dir_parent_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] childReqValid,
  input logic [N-1:0] childReqReady,
  input logic [N-1:0] childRspValid,
  input logic [N-1:0] childRspReady,
  input logic         grantValid,
  input logic         downValid,
  input logic [1:0]   downState
);

  // R8: a single response is accepted, and one is always accepted when offered
  p_one_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(childRspReady));
  p_rsp_taken_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|childRspValid) |-> (|childRspReady));
  p_rsp_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|childRspValid) |-> (childReqReady == '0));

  // R9: at most one request accepted, never one not offered
  p_one_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(childReqReady) && ((childReqReady & ~childReqValid) == '0));

  // R4: a grant message follows an accepted request by one cycle
  p_grant_after_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $past(|childReqReady));

  // R2: a request is never granted and downgraded for in the same decision
  p_grant_xor_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && downValid));

  // R5: a downgrade never leaves the child in M
  p_down_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    downValid |-> (downState == 2'd0 || downState == 2'd1));

endmodule

bind msi_dir_parent msi_dir_parent_chk #(.N(N)) u_chk (.*);

// File: tb/msi_dir_parent_tb.sv
`timescale 1ns/1ps
module msi_dir_parent_tb;

  localparam int N = 3, AW = 2, DW = 8, CW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]    childReqValid = '0, childRspValid = '0;
  logic [N-1:0]    childReqReady, childRspReady;
  logic [N*AW-1:0] childReqAddr = '0, childRspAddr = '0;
  logic [N*2-1:0]  childReqState = '0, childRspState = '0;
  logic [N*DW-1:0] childRspData = '0;
  logic            grantValid, grantHasData, downValid;
  logic [CW-1:0]   grantChild, downChild;
  logic [AW-1:0]   grantAddr, downAddr;
  logic [1:0]      grantState, downState;
  logic [DW-1:0]   grantData;

  msi_dir_parent #(.N(N), .AW(AW), .DW(DW)) u_dut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one-cycle stimulus and the expected registered outputs
  typedef struct packed {
    logic       isRsp;
    logic [1:0] kid;
    logic [1:0] addr;
    logic [1:0] st;
    logic [7:0] data;
    logic       eG;
    logic       eHas;
    logic [7:0] eData;
    logic       eD;
    logic [1:0] eDKid;
    logic [1:0] eDSt;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 2'd1, 2'd1, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 2'd0, 4'd3}, // R3 first S, data
    '{1'b0, 2'd1, 2'd1, 2'd1, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 2'd0, 4'd2}, // R2 S shares with S
    '{1'b0, 2'd2, 2'd1, 2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 2'd0, 4'd5}, // R5 lowest clash, to I
    '{1'b0, 2'd0, 2'd1, 2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd6}, // R6 waiting requester held
    '{1'b0, 2'd2, 2'd1, 2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 2'd0, 4'd5}, // R5 next clash
    '{1'b0, 2'd2, 2'd1, 2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd6}, // R6 no repeat downgrade
    '{1'b1, 2'd0, 2'd1, 2'd0, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd7}, // R7 S answer, no write
    '{1'b1, 2'd1, 2'd1, 2'd0, 8'h66, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd7}, // R7
    '{1'b0, 2'd2, 2'd1, 2'd2, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 2'd0, 4'd4}, // R4 M granted, old data
    '{1'b0, 2'd0, 2'd1, 2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 2'd1, 4'd5}, // R5 S request, to S
    '{1'b1, 2'd2, 2'd1, 2'd1, 8'hA5, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd7}, // R7 M answer written
    '{1'b0, 2'd0, 2'd1, 2'd1, 8'h00, 1'b1, 1'b1, 8'hA5, 1'b0, 2'd0, 2'd0, 4'd7}, // R7 data visible
    '{1'b0, 2'd0, 2'd1, 2'd2, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 2'd0, 4'd2}, // R2 M clashes with S
    '{1'b1, 2'd2, 2'd1, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd7}, // R7
    '{1'b0, 2'd0, 2'd1, 2'd2, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd3}, // R3 upgrade, no data
    '{1'b1, 2'd0, 2'd1, 2'd0, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd0, 4'd7}, // R7 voluntary write-back
    '{1'b0, 2'd1, 2'd1, 2'd1, 8'h00, 1'b1, 1'b1, 8'h3C, 1'b0, 2'd0, 2'd0, 4'd7}, // R7 write-back kept
    '{1'b0, 2'd1, 2'd2, 2'd2, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 2'd0, 2'd0, 4'd4}  // R4 other line untouched
  };

  task automatic clearIn();
    childReqValid = '0;
    childRspValid = '0;
  endtask

  task automatic setReq(int k, int a, int s);
    childReqValid[k] = 1'b1;
    childReqAddr[k*AW +: AW] = AW'(a);
    childReqState[k*2 +: 2] = 2'(s);
  endtask

  task automatic setRsp(int k, int a, int s, int d);
    childRspValid[k] = 1'b1;
    childRspAddr[k*AW +: AW] = AW'(a);
    childRspState[k*2 +: 2] = 2'(s);
    childRspData[k*DW +: DW] = DW'(d);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check("R1", {29'd0, grantValid, downValid, |childReqReady}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] act, exp;
      clearIn();
      if (VEC[v].isRsp) setRsp(VEC[v].kid, VEC[v].addr, VEC[v].st, VEC[v].data);
      else setReq(VEC[v].kid, VEC[v].addr, VEC[v].st);
      @(negedge clk);
      clearIn();
      act = {grantValid,
             grantValid ? {grantChild, grantAddr, grantState, grantHasData, grantData} : 15'd0,
             downValid,
             downValid ? {downChild, downAddr, downState} : 6'd0, 9'd0};
      exp = {VEC[v].eG,
             VEC[v].eG ? {VEC[v].kid, VEC[v].addr, VEC[v].st, VEC[v].eHas, VEC[v].eData} : 15'd0,
             VEC[v].eD,
             VEC[v].eD ? {VEC[v].eDKid, VEC[v].addr, VEC[v].eDSt} : 6'd0, 9'd0};
      check($sformatf("R%0d row %0d", VEC[v].tag, v), act, exp);
      @(negedge clk);
    end

    // R9: children 0 and 2 both ask for line 3 in S; last grant went to child 1
    setReq(0, 3, 1);
    setReq(2, 3, 1);
    #1 check("R9 ready first", {29'd0, childReqReady}, 32'b100);
    @(negedge clk);
    check("R9 grant first", {28'd0, grantValid, grantChild, grantHasData}, {28'd0, 1'b1, 2'd2, 1'b1});
    #1 check("R9 ready second", {29'd0, childReqReady}, 32'b001);
    @(negedge clk);
    check("R9 grant second", {28'd0, grantValid, grantChild, grantHasData}, {28'd0, 1'b1, 2'd0, 1'b1});
    @(negedge clk);
    // R3: child 2 already holds S, so no data this time
    check("R9 R3 grant third", {20'd0, grantValid, grantChild, grantHasData, grantData},
          {20'd0, 1'b1, 2'd2, 1'b0, 8'h00});
    clearIn();
    @(negedge clk);

    // R8: response from child 1 (M on line 2) beats a request from child 0
    setRsp(1, 2, 1, 8'h11);
    setReq(0, 2, 1);
    #1 check("R8 priority", {26'd0, childReqReady, childRspReady}, {26'd0, 3'b000, 3'b010});
    @(negedge clk);
    childRspValid = '0;
    check("R8 no grant", {31'd0, grantValid}, 32'd0);
    @(negedge clk);
    clearIn();
    check("R7 R8 data after M answer", {22'd0, grantValid, grantHasData, grantData},
          {22'd0, 1'b1, 1'b1, 8'h11});
    @(negedge clk);

    // R8: lowest-index response wins
    setRsp(0, 0, 0, 0);
    setRsp(2, 0, 0, 0);
    #1 check("R8 lowest index", {29'd0, childRspReady}, 32'b001);
    @(negedge clk);
    clearIn();
    @(negedge clk);

    // R1: reset again wipes data and directory
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    setReq(2, 1, 2);
    @(negedge clk);
    clearIn();
    check("R1 after reset", {22'd0, grantValid, grantHasData, grantData}, {22'd0, 1'b1, 1'b1, 8'h00});
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule